// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter. Every clock it receives a small count from each of several sub-event sources and the current privilege level of the thread being observed. A configuration word chooses which sub-event sources are added together (the unit mask), a per-cycle threshold with an optional inverted sense, an optional rising-edge mode, which privilege levels may count, an enable and an interrupt enable. The qualified increment is added to a wide counter that software can load and read at any time. When the counter wraps past its largest value a sticky overflow flag is set and, if enabled, a one-cycle interrupt pulse is raised.

The 8-bit event code in the configuration is stored and read back but not decoded here; the surrounding core routes the matching sub-event sources onto the inputs. The configuration and the counter are each written with a one-cycle write strobe; the new values are visible from the following cycle.

Top module: `pec_counter`

## Requirements
- R1: After reset the counter value, the overflow flag, the interrupt output and the configuration word are all zero.
- R2: The configuration word is laid out as bits [7:0] event code, [15:8] unit mask, [23:16] threshold, bit 24 invert, bit 25 edge mode, bit 26 kernel enable, bit 27 user enable, bit 28 counter enable, bit 29 interrupt enable; a write is read back unchanged on `cfg_rdata` from the next cycle.
- R3: The per-cycle total is the sum of the sub-event inputs whose unit-mask bit is set (sub-event i uses mask bit i); with a zero threshold and edge mode off, the counter adds that full total each cycle.
- R4: With a nonzero threshold and invert clear, the counter adds exactly one in a cycle whose total is greater than or equal to the threshold, and nothing otherwise.
- R5: With a nonzero threshold and invert set, the counter adds exactly one in a cycle whose total is strictly below the threshold, and nothing otherwise.
- R6: In edge mode the counter adds one only in a cycle where the qualified condition (total nonzero when the threshold is zero, otherwise the threshold test, and privilege passing) is true and was false in the previous cycle; the remembered previous condition is cleared whenever the enable is clear or the configuration is written, so a condition already true then counts once more.
- R7: With the kernel enable set, counting happens at privilege level 0; with the user enable set, counting happens at levels 1, 2 and 3; a level whose enable is clear adds nothing.
- R8: When both the kernel and the user enables are clear, all privilege levels count.
- R9: With the counter enable clear, the counter value does not change except by a software write.
- R10: The counter wraps from all ones to zero; the wrap sets the overflow flag, which stays set until the next software write of the counter clears it.
- R11: On a wrap with the interrupt enable set, `irq` is high for exactly the cycle in which the wrapped value first appears; with the interrupt enable clear no pulse is produced.
- R12: A software write of the counter takes priority over an increment in the same cycle: the next value is the written value.
- R13: In a cycle where the configuration is written, the increment is computed with the configuration that was in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 30 | Configuration word to write |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter value to write |
| sub_evt | input | NUM_SUB*SUB_W | Packed per-cycle counts, sub-event i in bits [i*SUB_W +: SUB_W] |
| priv_lvl | input | 2 | Current privilege level, 0 is kernel |
| cfg_rdata | output | 30 | Configuration word in force |
| count | output | CNT_W | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt pulse |

## Verification
The bench builds the block with four sub-event sources of three bits each and a 24-bit counter, which keeps the per-cycle total below 29 while a preload to just under the top value reaches a wrap within one or two cycles. The small source count lets the unit mask select, skip and combine every source in a handful of patterns, and thresholds near the middle of the total range place cycles on both sides of the comparison and exactly on it. A reference model in the bench tracks the edge history and privilege gating separately from the design, so mixed sequences of configuration rewrites, disables and privilege changes can be scored cycle by cycle.

// File: rtl/pec_pkg.sv
package pec_pkg;

  localparam int EVSEL_W = 8;
  localparam int UMASK_W = 8;
  localparam int THR_W   = 8;
  localparam int CFG_W   = EVSEL_W + UMASK_W + THR_W + 6;
  localparam int CMP_W   = 16;

  typedef struct packed {
    logic               irq_en;
    logic               en;
    logic               usr;
    logic               os;
    logic               edge_m;
    logic               inv;
    logic [THR_W-1:0]   thr;
    logic [UMASK_W-1:0] umask;
    logic [EVSEL_W-1:0] evsel;
  } pec_cfg_t;

  // Privilege filter: an all-clear pair of enables means both levels count.
  function automatic logic priv_pass(input logic os, input logic usr,
                                     input logic [1:0] lvl);
    logic none;
    none = ~(os | usr);
    if (lvl == 2'd0) return os | none;
    return usr | none;
  endfunction

  // Per-cycle threshold test; with a zero threshold any activity qualifies.
  function automatic logic thr_cond(input logic [CMP_W-1:0] total,
                                    input logic [THR_W-1:0] thr,
                                    input logic inv);
    logic [CMP_W-1:0] thr_x;
    thr_x = {{(CMP_W-THR_W){1'b0}}, thr};
    if (thr == '0) return total != '0;
    if (inv) return total < thr_x;
    return total >= thr_x;
  endfunction

endpackage

// File: rtl/pec_sum.sv
module pec_sum #(
  parameter int NUM_SUB = 8,
  parameter int SUB_W   = 3,
  parameter int SUM_W   = SUB_W + $clog2(NUM_SUB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SUB*SUB_W-1:0] sub_evt,
  input  logic [NUM_SUB-1:0]       mask,
  output logic [SUM_W-1:0]         total
);

  logic [SUM_W-1:0] lane [NUM_SUB];

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_lane
    assign lane[i] = mask[i] ? {{(SUM_W-SUB_W){1'b0}}, sub_evt[i*SUB_W +: SUB_W]} : '0;
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_SUB; i++) total = total + lane[i];
  end

  assert_nomask_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (total == '0));

endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
#(
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] total,
  input  logic [1:0]       priv_lvl,
  input  logic             cfg_we,
  input  logic             en,
  input  logic             os,
  input  logic             usr,
  input  logic             edge_m,
  input  logic             inv,
  input  logic [THR_W-1:0] thr,
  output logic [SUM_W-1:0] inc
);

  logic [CMP_W-1:0] total_x;
  logic             gate_ok;
  logic             cond_raw;
  logic             qual;
  logic             hist_q;
  logic             rise;

  assign total_x  = {{(CMP_W-SUM_W){1'b0}}, total};
  assign gate_ok  = en & priv_pass(os, usr, priv_lvl);
  assign cond_raw = thr_cond(total_x, thr, inv);
  assign qual     = gate_ok & cond_raw;
  assign rise     = qual & ~hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= (en && !cfg_we) ? qual : 1'b0;
  end

  always_comb begin
    if (!gate_ok)         inc = '0;
    else if (edge_m)      inc = {{(SUM_W-1){1'b0}}, rise};
    else if (thr == '0)   inc = total;
    else                  inc = {{(SUM_W-1){1'b0}}, cond_raw};
  end

  assert_edge_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_m |-> (inc <= SUM_W'(1)));
  assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && en && !cfg_we && qual) |=> (!edge_m || (inc == '0)));
  assert_thr_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0) |-> (inc <= SUM_W'(1)));
  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (inc == '0));
  assert_priv_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv_lvl == 2'd0) && !os && usr) |-> (inc == '0));

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CNT_W = 48,
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] inc,
  input  logic             irq_en,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq
);

  logic [CNT_W:0] sum_x;
  logic           wrap;

  assign sum_x = {1'b0, count} + {{(CNT_W+1-SUM_W){1'b0}}, inc};
  assign wrap  = sum_x[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else if (cnt_we) begin
      count    <= cnt_wdata;
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      count    <= sum_x[CNT_W-1:0];
      ovf_flag <= ovf_flag | wrap;
      irq      <= wrap & irq_en;
    end
  end

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !cnt_we) |=> ovf_flag);
  assert_irq_needs_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
  assert_no_count_drift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && (inc == '0)) |=> $stable(count));

endmodule

// File: rtl/pec_counter.sv
module pec_counter
  import pec_pkg::*;
#(
  parameter int NUM_SUB = 8,
  parameter int SUB_W   = 3,
  parameter int CNT_W   = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     cnt_we,
  input  logic [CNT_W-1:0]         cnt_wdata,
  input  logic [NUM_SUB*SUB_W-1:0] sub_evt,
  input  logic [1:0]               priv_lvl,
  output logic [CFG_W-1:0]         cfg_rdata,
  output logic [CNT_W-1:0]         count,
  output logic                     ovf_flag,
  output logic                     irq
);

  localparam int SUM_W = SUB_W + $clog2(NUM_SUB);

  pec_cfg_t         cfg_q;
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= pec_cfg_t'(cfg_wdata);
  end

  assign cfg_rdata = cfg_q;

  pec_sum #(.NUM_SUB(NUM_SUB), .SUB_W(SUB_W), .SUM_W(SUM_W)) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .sub_evt (sub_evt),
    .mask    (cfg_q.umask[NUM_SUB-1:0]),
    .total   (total)
  );

  pec_qualify #(.SUM_W(SUM_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .total    (total),
    .priv_lvl (priv_lvl),
    .cfg_we   (cfg_we),
    .en       (cfg_q.en),
    .os       (cfg_q.os),
    .usr      (cfg_q.usr),
    .edge_m   (cfg_q.edge_m),
    .inv      (cfg_q.inv),
    .thr      (cfg_q.thr),
    .inc      (inc)
  );

  pec_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (inc),
    .irq_en    (cfg_q.irq_en),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .count     (count),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
  );

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

endmodule

// File: tb/pec_counter_bench.sv
`timescale 1ns/100ps
module pec_counter_bench;
  localparam int NS   = 4;
  localparam int SW   = 3;
  localparam int CW   = 24;
  localparam int CFGW = 30;

  typedef struct {
    logic [CW-1:0]   cnt;
    logic            ovf;
    logic            irq;
    logic [CFGW-1:0] cfg;
    string           req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFGW-1:0] cfg_wdata = '0;
  logic cnt_we = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [NS*SW-1:0] sub_evt = '0;
  logic [1:0] priv_lvl = 2'd0;
  logic [CFGW-1:0] cfg_rdata;
  logic [CW-1:0] count;
  logic ovf_flag, irq;

  int total = 0;
  int bad = 0;
  exp_t sb [$];

  // reference state
  logic [CFGW-1:0] m_cfg = '0;
  logic [CW-1:0]   m_cnt = '0;
  logic            m_ovf = 1'b0;
  logic            m_irq = 1'b0;
  logic            m_hist = 1'b0;

  always #2.5 clk = ~clk;

  pec_counter #(.NUM_SUB(NS), .SUB_W(SW), .CNT_W(CW)) u_pec_counter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .sub_evt(sub_evt),
    .priv_lvl(priv_lvl), .cfg_rdata(cfg_rdata), .count(count),
    .ovf_flag(ovf_flag), .irq(irq));

  function automatic logic [CFGW-1:0] mk_cfg(input logic [7:0] um, input logic [7:0] th,
      input logic iv, input logic ed, input logic os, input logic us,
      input logic en, input logic ie);
    mk_cfg = {ie, en, us, os, ed, iv, th, um, 8'h3c};
  endfunction

  function automatic logic [NS*SW-1:0] pk(input int a0, input int a1, input int a2, input int a3);
    pk = {3'(a3), 3'(a2), 3'(a1), 3'(a0)};
  endfunction

  task automatic step(input logic [NS*SW-1:0] sv, input logic [1:0] pl,
                      input logic cwe, input logic [CFGW-1:0] cwd,
                      input logic nwe, input logic [CW-1:0] nwd, input string req);
    int s; logic en, os, us, ed, iv, ie, pass, hit, q; int th, inc;
    exp_t e; logic [CW:0] wide;
    @(negedge clk);
    sub_evt = sv; priv_lvl = pl; cfg_we = cwe; cfg_wdata = cwd;
    cnt_we = nwe; cnt_wdata = nwd;
    s = 0;
    for (int i = 0; i < NS; i++) if (m_cfg[8+i]) s += int'(sv[i*SW +: SW]);
    ie = m_cfg[29]; en = m_cfg[28]; us = m_cfg[27]; os = m_cfg[26];
    ed = m_cfg[25]; iv = m_cfg[24]; th = int'(m_cfg[23:16]);
    if (!os && !us) pass = 1'b1;
    else pass = (pl == 2'd0) ? os : us;
    if (th == 0) hit = (s > 0);
    else if (iv) hit = (s < th);
    else hit = (s >= th);
    q = en && pass && hit;
    if (!(en && pass)) inc = 0;
    else if (ed) inc = (q && !m_hist) ? 1 : 0;
    else if (th == 0) inc = s;
    else inc = hit ? 1 : 0;
    m_hist = (en && !cwe) ? q : 1'b0;
    if (nwe) begin
      m_cnt = nwd; m_ovf = 1'b0; m_irq = 1'b0;
    end else begin
      wide = {1'b0, m_cnt} + (CW+1)'(inc);
      m_cnt = wide[CW-1:0];
      m_irq = wide[CW] && ie;
      m_ovf = m_ovf | wide[CW];
    end
    if (cwe) m_cfg = cwd;
    e.cnt = m_cnt; e.ovf = m_ovf; e.irq = m_irq; e.cfg = m_cfg; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input logic [NS*SW-1:0] sv, input logic [1:0] pl, input string req);
    step(sv, pl, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic wcfg(input logic [CFGW-1:0] c, input string req);
    step('0, 2'd0, 1'b1, c, 1'b0, '0, req);
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (count !== e.cnt || ovf_flag !== e.ovf || irq !== e.irq || cfg_rdata !== e.cfg) begin
        bad++;
        $display("FAIL %s: actual cnt=%0h ovf=%0b irq=%0b cfg=%0h expected cnt=%0h ovf=%0b irq=%0b cfg=%0h",
                 e.req, count, ovf_flag, irq, cfg_rdata, e.cnt, e.ovf, e.irq, e.cfg);
      end
    end
  end

  initial begin
    #(5ns * 20000);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (count !== '0 || ovf_flag !== 1'b0 || irq !== 1'b0 || cfg_rdata !== '0) begin
      bad++;
      $display("FAIL R1: actual cnt=%0h ovf=%0b irq=%0b cfg=%0h expected all zero",
               count, ovf_flag, irq, cfg_rdata);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: mask 0101 selects sources 0 and 2, zero threshold adds totals
    wcfg(mk_cfg(8'h05, 8'd0, 0, 0, 1, 1, 1, 0), "R2");
    idle(pk(5, 2, 3, 7), 2'd0, "R3");
    idle(pk(1, 7, 0, 7), 2'd1, "R3");
    wcfg(mk_cfg(8'h0f, 8'd0, 0, 0, 1, 1, 1, 0), "R2");
    idle(pk(7, 7, 7, 7), 2'd3, "R3");
    idle(pk(0, 0, 0, 0), 2'd3, "R3");

    // R4: threshold 6
    wcfg(mk_cfg(8'h03, 8'd6, 0, 0, 1, 1, 1, 0), "R4");
    idle(pk(5, 3, 0, 0), 2'd0, "R4");
    idle(pk(2, 2, 7, 7), 2'd0, "R4");
    idle(pk(3, 3, 0, 0), 2'd0, "R4");
    idle(pk(0, 5, 0, 0), 2'd0, "R4");

    // R5: inverted threshold 6
    wcfg(mk_cfg(8'h03, 8'd6, 1, 0, 1, 1, 1, 0), "R5");
    idle(pk(5, 3, 0, 0), 2'd0, "R5");
    idle(pk(2, 2, 0, 0), 2'd0, "R5");
    idle(pk(3, 3, 0, 0), 2'd0, "R5");
    idle(pk(0, 0, 0, 0), 2'd0, "R5");

    // R6: edge mode, threshold 1
    wcfg(mk_cfg(8'h01, 8'd1, 0, 1, 1, 1, 1, 0), "R6");
    idle(pk(2, 0, 0, 0), 2'd0, "R6");
    idle(pk(3, 0, 0, 0), 2'd0, "R6");
    idle(pk(1, 0, 0, 0), 2'd0, "R6");
    idle(pk(0, 0, 0, 0), 2'd0, "R6");
    idle(pk(4, 0, 0, 0), 2'd0, "R6");
    step(pk(4, 0, 0, 0), 2'd0, 1'b1, mk_cfg(8'h01, 8'd1, 0, 1, 1, 1, 1, 0), 1'b0, '0, "R6");
    idle(pk(4, 0, 0, 0), 2'd0, "R6");
    idle(pk(4, 0, 0, 0), 2'd0, "R6");
    step(pk(4, 0, 0, 0), 2'd0, 1'b1, mk_cfg(8'h01, 8'd1, 0, 1, 1, 1, 0, 0), 1'b0, '0, "R6");
    idle(pk(4, 0, 0, 0), 2'd0, "R6");
    step(pk(4, 0, 0, 0), 2'd0, 1'b1, mk_cfg(8'h01, 8'd1, 0, 1, 1, 1, 1, 0), 1'b0, '0, "R6");
    idle(pk(4, 0, 0, 0), 2'd0, "R6");
    // edge with zero threshold
    wcfg(mk_cfg(8'h01, 8'd0, 0, 1, 1, 1, 1, 0), "R6");
    idle(pk(6, 0, 0, 0), 2'd0, "R6");
    idle(pk(6, 0, 0, 0), 2'd0, "R6");

    // R7: kernel only, then user only
    wcfg(mk_cfg(8'h02, 8'd0, 0, 0, 1, 0, 1, 0), "R7");
    idle(pk(0, 3, 0, 0), 2'd0, "R7");
    idle(pk(0, 3, 0, 0), 2'd2, "R7");
    wcfg(mk_cfg(8'h02, 8'd0, 0, 0, 0, 1, 1, 0), "R7");
    idle(pk(0, 4, 0, 0), 2'd0, "R7");
    idle(pk(0, 4, 0, 0), 2'd1, "R7");
    idle(pk(0, 4, 0, 0), 2'd3, "R7");
    // R8: both clear counts everywhere
    wcfg(mk_cfg(8'h02, 8'd0, 0, 0, 0, 0, 1, 0), "R8");
    idle(pk(0, 2, 0, 0), 2'd0, "R8");
    idle(pk(0, 5, 0, 0), 2'd2, "R8");

    // R9: disabled
    wcfg(mk_cfg(8'h0f, 8'd0, 0, 0, 1, 1, 0, 1), "R9");
    idle(pk(7, 7, 7, 7), 2'd0, "R9");
    idle(pk(7, 7, 7, 7), 2'd3, "R9");

    // R10/R11: wrap with interrupt enabled
    wcfg(mk_cfg(8'h0f, 8'd0, 0, 0, 1, 1, 1, 1), "R11");
    step('0, 2'd0, 1'b0, '0, 1'b1, {CW{1'b1}} - CW'(3), "R12");
    idle(pk(2, 2, 2, 2), 2'd0, "R10");
    idle(pk(1, 0, 0, 0), 2'd0, "R11");
    idle(pk(0, 0, 0, 0), 2'd0, "R10");
    // R12: write beats increment and clears overflow
    step(pk(7, 7, 7, 7), 2'd0, 1'b0, '0, 1'b1, {CW{1'b1}}, "R12");
    idle(pk(1, 0, 0, 0), 2'd0, "R11");
    // wrap without interrupt enable
    wcfg(mk_cfg(8'h0f, 8'd0, 0, 0, 1, 1, 1, 0), "R11");
    step('0, 2'd0, 1'b0, '0, 1'b1, {CW{1'b1}}, "R12");
    idle(pk(3, 0, 0, 0), 2'd0, "R11");

    // R13: config write cycle uses old configuration
    step(pk(1, 2, 3, 4), 2'd0, 1'b1, mk_cfg(8'h08, 8'd0, 0, 0, 1, 1, 1, 0), 1'b0, '0, "R13");
    idle(pk(1, 2, 3, 4), 2'd0, "R13");

    // mixed sequences
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        step(12'($urandom), 2'($urandom), 1'b1,
             mk_cfg(8'($urandom), 8'($urandom_range(0, 12)), r[4], r[5], r[6], r[7],
                    r[8] | r[9], r[10]), 1'b0, '0, "R13");
      else if (r[3:0] == 4'd1)
        step(12'($urandom), 2'($urandom), 1'b0, '0, 1'b1,
             {CW{1'b1}} - CW'($urandom_range(0, 20)), "R12");
      else
        idle(12'($urandom), 2'($urandom), "R6");
    end

    repeat (3) @(posedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule